// File: doc/BRIEF.md
# Register-Window AXI4-Lite Master Bridge

This block lets a narrow 16-bit host bus run single 32-bit AXI4-Lite transactions. It holds eight 16-bit registers, selected by a 3-bit index. The host first writes the target address and, for a write, the data, each as two 16-bit halves. It then writes a command code into the control register. The bridge runs exactly one AXI4-Lite read or write and then sets one sticky event bit to report the outcome: completion, error response or timeout. For a read, it also keeps the returned word in two read-only halves.

An event mask in the control register selects which sticky events drive the interrupt output. Two of the command codes add 4 to the stored address after a successful transfer, so the host can walk through consecutive words without reloading the address. A cycle counter abandons a transfer that gets no response within `TimeoutCycles` cycles of command acceptance. A level on the downstream interrupt input is also latched as a sticky event.

Top module: `axil_window_bridge`

## Requirements
- R1: The register indices are 0 status, 1 control, 2 address low, 3 address high, 4 write-data low, 5 write-data high, 6 read-data low and 7 read-data high. After reset all registers read 0, except status, which reads 0x0020 (bit 5 = initialisation done). The interrupt output is low after reset.
- R2: Command code 0x8 or 0x9 in control bits 3:0 starts one AXI write. Its address is {address high, address low} and its data is {write-data high, write-data low}. All four byte strobes are asserted. An OKAY response (resp = 2'b00) sets status bit 14.
- R3: Command code 0xA or 0xB starts one AXI read. An OKAY response sets status bit 15 and status bit 7 (read data available), and places read data bits 31:16 in register 7 and bits 15:0 in register 6. Bit 7 is cleared when a read command is accepted.
- R4: After a successful 0x9 or 0xB transfer, the stored address increases by 4, modulo 2^32. After 0x8 or 0xA, or after any failed transfer, the address is unchanged.
- R5: Any non-OKAY response sets status bit 12 (error). A read that fails leaves registers 6 and 7 unchanged.
- R6: If no response arrives within `TimeoutCycles` cycles of acceptance, the bridge sets status bit 13, drops its valid signals and becomes idle.
- R7: Each transfer sets exactly one of status bits 15, 14, 13 and 12.
- R8: Status bit 6 (busy) is high from command acceptance until the cycle of the final event update. While busy, writes of a command and writes to registers 2 to 5 are ignored, and the AXI address is held stable.
- R9: Event bits 15:11 are sticky. Writing a 1 to one of them in status clears it; writing a 0 leaves it unchanged.
- R10: A high level on the downstream interrupt input sets status bit 11, which stays set after the input falls.
- R11: Control bits 15:11 are an enable mask for status bits 15:11 and read back as written; all other control bits read 0. The interrupt output is the OR of every event bit that is set and enabled.
- R12: Command code 0x0 and every code other than 0x8 to 0xB start nothing. Busy and the event bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 3 | Register index |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Register selected by hostAddr (combinational) |
| irqIn | input | 1 | Downstream interrupt level |
| irqOut | output | 1 | Interrupt request |
| awValid | output | 1 | AXI write address valid |
| awReady | input | 1 | AXI write address ready |
| awAddr | output | 32 | AXI write address |
| wValid | output | 1 | AXI write data valid |
| wReady | input | 1 | AXI write data ready |
| wData | output | 32 | AXI write data |
| wStrb | output | 4 | AXI write strobes |
| bValid | input | 1 | AXI write response valid |
| bReady | output | 1 | AXI write response ready |
| bResp | input | 2 | AXI write response |
| arValid | output | 1 | AXI read address valid |
| arReady | input | 1 | AXI read address ready |
| arAddr | output | 32 | AXI read address |
| rValid | input | 1 | AXI read data valid |
| rReady | output | 1 | AXI read data ready |
| rData | input | 32 | AXI read data |
| rResp | input | 2 | AXI read response |

## Verification
The hardest case to reach from the ports is a command write that lands while a transfer is still in flight. Reaching it needs a slow slave and host writes timed inside the busy window. The bench slave has a programmable handshake delay, so a long delay holds the bridge busy while a second command and a new address half are written. The slave's transaction counters and the address readback then show that both were dropped. A hang switch on the same slave withholds every ready signal, which drives the timeout path. Random runs mix delays and error responses, and directed cases cover address wrap and the interrupt mask.

// File: rtl/axil_bridge_pkg.sv
package axil_bridge_pkg;
  localparam logic [2:0] RegStatus = 3'd0;
  localparam logic [2:0] RegCtrl   = 3'd1;
  localparam logic [2:0] RegAddrLo = 3'd2;
  localparam logic [2:0] RegAddrHi = 3'd3;
  localparam logic [2:0] RegWdLo   = 3'd4;
  localparam logic [2:0] RegWdHi   = 3'd5;
  localparam logic [2:0] RegRdLo   = 3'd6;
  localparam logic [2:0] RegRdHi   = 3'd7;

  localparam int EvtW = 5;  // status / mask bits 15:11

  // strobes from sequencer to register datapath
  typedef struct packed {
    logic setRdDone;
    logic setWrDone;
    logic setTmo;
    logic setErr;
    logic capRd;
    logic incAddr;
    logic clrRdAvail;
  } strobe_t;
endpackage

// File: rtl/axil_bridge_seq.sv
module axil_bridge_seq
  import axil_bridge_pkg::*;
#(
  parameter int TimeoutCycles = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdGo,
  input  logic       cmdRead,
  input  logic       cmdInc,
  input  logic       awReady,
  input  logic       wReady,
  input  logic       bValid,
  input  logic [1:0] bResp,
  input  logic       arReady,
  input  logic       rValid,
  input  logic [1:0] rResp,
  output logic       awValid,
  output logic       wValid,
  output logic       bReady,
  output logic       arValid,
  output logic       rReady,
  output logic       busy,
  output strobe_t    strb
);
  localparam int CntW = $clog2(TimeoutCycles + 1);
  localparam logic [CntW-1:0] CntLast = CntW'(TimeoutCycles - 1);

  typedef enum logic [2:0] {StIdle, StWrAddr, StWrResp, StRdAddr, StRdResp} state_e;

  state_e          state, stateNxt;
  logic            awDone, wDone, incLat;
  logic [CntW-1:0] tmoCnt;
  logic            fin, finErr, finRd, tmoHit;

  always_comb begin
    busy    = (state != StIdle);
    awValid = (state == StWrAddr) && !awDone;
    wValid  = (state == StWrAddr) && !wDone;
    bReady  = (state == StWrResp);
    arValid = (state == StRdAddr);
    rReady  = (state == StRdResp);
    finRd   = (state == StRdResp);
    fin     = ((state == StWrResp) && bValid) || (finRd && rValid);
    finErr  = finRd ? (rResp != 2'b00) : (bResp != 2'b00);
    tmoHit  = busy && !fin && (tmoCnt == CntLast);

    strb.setRdDone  = fin && !finErr && finRd;
    strb.setWrDone  = fin && !finErr && !finRd;
    strb.setErr     = fin && finErr;
    strb.setTmo     = tmoHit;
    strb.capRd      = fin && !finErr && finRd;
    strb.incAddr    = fin && !finErr && incLat;
    strb.clrRdAvail = (state == StIdle) && cmdGo && cmdRead;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      StIdle:   if (cmdGo) stateNxt = cmdRead ? StRdAddr : StWrAddr;
      StWrAddr: if ((awDone || awReady) && (wDone || wReady)) stateNxt = StWrResp;
      StRdAddr: if (arReady) stateNxt = StRdResp;
      StWrResp, StRdResp: if (fin) stateNxt = StIdle;
      default:  stateNxt = StIdle;
    endcase
    if (tmoHit) stateNxt = StIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= StIdle;
      tmoCnt <= '0;
      awDone <= 1'b0;
      wDone  <= 1'b0;
      incLat <= 1'b0;
    end else begin
      state  <= stateNxt;
      tmoCnt <= busy ? tmoCnt + 1'b1 : '0;
      awDone <= (state == StWrAddr) && (awDone || awReady);
      wDone  <= (state == StWrAddr) && (wDone || wReady);
      if (state == StIdle && cmdGo) incLat <= cmdInc;
    end
  end
endmodule

// File: rtl/axil_bridge_regs.sv
module axil_bridge_regs
  import axil_bridge_pkg::*;
#(
  parameter int RegW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hostAddr,
  input  logic              hostWrEn,
  input  logic [RegW-1:0]   hostWrData,
  output logic [RegW-1:0]   hostRdData,
  input  logic              busy,
  input  strobe_t           strb,
  input  logic [2*RegW-1:0] rdWord,
  input  logic              irqIn,
  output logic [2*RegW-1:0] xferAddr,
  output logic [2*RegW-1:0] xferData,
  output logic              cmdGo,
  output logic              cmdRead,
  output logic              cmdInc,
  output logic [EvtW-1:0]   enMask,
  output logic              irqOut
);
  localparam int WordW = 2 * RegW;

  logic [WordW-1:0] addrQ, wdQ, rdQ;
  logic [EvtW-1:0]  evtQ, evtSet, evtClr;
  logic             rdAvail, initDone;
  logic             wrSel [8];

  generate
    for (genvar i = 0; i < 8; i++) begin : g_sel
      assign wrSel[i] = hostWrEn && (hostAddr == 3'(i));
    end
  endgenerate

  assign cmdGo   = wrSel[RegCtrl] && !busy && (hostWrData[3:2] == 2'b10);
  assign cmdRead = hostWrData[1];
  assign cmdInc  = hostWrData[0];

  assign evtSet = {strb.setRdDone, strb.setWrDone, strb.setTmo, strb.setErr, irqIn};
  assign evtClr = wrSel[RegStatus] ? hostWrData[RegW-1 -: EvtW] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdQ      <= '0;
      rdQ      <= '0;
      evtQ     <= '0;
      enMask   <= '0;
      rdAvail  <= 1'b0;
      initDone <= 1'b0;
    end else begin
      initDone <= 1'b1;
      evtQ     <= evtSet | (evtQ & ~evtClr);
      if (wrSel[RegCtrl]) enMask <= hostWrData[RegW-1 -: EvtW];
      if (strb.capRd) begin
        rdQ     <= rdWord;
        rdAvail <= 1'b1;
      end else if (strb.clrRdAvail) begin
        rdAvail <= 1'b0;
      end
      if (strb.incAddr) addrQ <= addrQ + WordW'(4);
      if (!busy) begin
        if (wrSel[RegAddrLo]) addrQ[RegW-1:0]     <= hostWrData;
        if (wrSel[RegAddrHi]) addrQ[WordW-1:RegW] <= hostWrData;
        if (wrSel[RegWdLo])   wdQ[RegW-1:0]       <= hostWrData;
        if (wrSel[RegWdHi])   wdQ[WordW-1:RegW]   <= hostWrData;
      end
    end
  end

  always_comb begin
    unique case (hostAddr)
      RegStatus: hostRdData = {evtQ, 3'b000, rdAvail, busy, initDone, 5'b00000};
      RegCtrl:   hostRdData = {enMask, (RegW - EvtW)'(0)};
      RegAddrLo: hostRdData = addrQ[RegW-1:0];
      RegAddrHi: hostRdData = addrQ[WordW-1:RegW];
      RegWdLo:   hostRdData = wdQ[RegW-1:0];
      RegWdHi:   hostRdData = wdQ[WordW-1:RegW];
      RegRdLo:   hostRdData = rdQ[RegW-1:0];
      default:   hostRdData = rdQ[WordW-1:RegW];
    endcase
  end

  assign xferAddr = addrQ;
  assign xferData = wdQ;
  assign irqOut   = |(evtQ & enMask);
endmodule

// File: rtl/axil_window_bridge.sv
module axil_window_bridge
  import axil_bridge_pkg::*;
#(
  parameter int TimeoutCycles = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  hostAddr,
  input  logic        hostWrEn,
  input  logic [15:0] hostWrData,
  output logic [15:0] hostRdData,
  input  logic        irqIn,
  output logic        irqOut,
  output logic        awValid,
  input  logic        awReady,
  output logic [31:0] awAddr,
  output logic        wValid,
  input  logic        wReady,
  output logic [31:0] wData,
  output logic [3:0]  wStrb,
  input  logic        bValid,
  output logic        bReady,
  input  logic [1:0]  bResp,
  output logic        arValid,
  input  logic        arReady,
  output logic [31:0] arAddr,
  input  logic        rValid,
  output logic        rReady,
  input  logic [31:0] rData,
  input  logic [1:0]  rResp
);
  strobe_t         strb;
  logic            busy, cmdGo, cmdRead, cmdInc;
  logic [31:0]     xferAddr;
  logic [EvtW-1:0] enMask;

  axil_bridge_regs #(.RegW(16)) u_regs (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .busy(busy), .strb(strb),
    .rdWord(rData), .irqIn(irqIn), .xferAddr(xferAddr), .xferData(wData),
    .cmdGo(cmdGo), .cmdRead(cmdRead), .cmdInc(cmdInc), .enMask(enMask),
    .irqOut(irqOut)
  );

  axil_bridge_seq #(.TimeoutCycles(TimeoutCycles)) u_seq (
    .clk(clk), .rstN(rstN), .cmdGo(cmdGo), .cmdRead(cmdRead), .cmdInc(cmdInc),
    .awReady(awReady), .wReady(wReady), .bValid(bValid), .bResp(bResp),
    .arReady(arReady), .rValid(rValid), .rResp(rResp), .awValid(awValid),
    .wValid(wValid), .bReady(bReady), .arValid(arValid), .rReady(rReady),
    .busy(busy), .strb(strb)
  );

  assign awAddr = xferAddr;
  assign arAddr = xferAddr;
  assign wStrb  = 4'hF;
endmodule

// File: rtl/axil_bridge_checker.sv
module axil_bridge_checker
  import axil_bridge_pkg::*;
#(
  parameter int TimeoutCycles = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input strobe_t         strb,
  input logic [EvtW-1:0] enMask,
  input logic            irqOut,
  input logic            awValid,
  input logic            awReady,
  input logic [31:0]     awAddr,
  input logic            wValid,
  input logic [3:0]      wStrb,
  input logic            arValid,
  input logic            arReady,
  input logic [31:0]     arAddr
);
  localparam int CntW = $clog2(TimeoutCycles + 2);
  logic [CntW-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else       busyCnt <= busy ? busyCnt + 1'b1 : '0;
  end

  a_r2_full_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> (wStrb == 4'hF));

  a_r7_single_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setRdDone, strb.setWrDone, strb.setTmo, strb.setErr}));

  a_r6_bounded_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < CntW'(TimeoutCycles)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(awValid || wValid || arValid));

  a_r8_aw_stable: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) |=> (!awValid || $stable(awAddr)));

  a_r8_ar_stable: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady) |=> (!arValid || $stable(arAddr)));

  a_r11_masked_irq: assert property (@(posedge clk) disable iff (!rstN)
    (enMask == '0) |-> !irqOut);
endmodule

bind axil_window_bridge axil_bridge_checker #(.TimeoutCycles(TimeoutCycles)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .strb(strb), .enMask(enMask), .irqOut(irqOut),
  .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .wValid(wValid),
  .wStrb(wStrb), .arValid(arValid), .arReady(arReady), .arAddr(arAddr)
);

// File: tb/axil_window_bridge_bench.sv
`timescale 1ns/1ps
module axil_window_bridge_bench;
  localparam int Tmo = 64;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [2:0]  hAddr = '0;
  logic        hWrEn = 1'b0;
  logic [15:0] hWrData = '0, hRdData;
  logic        irqIn = 1'b0, irqOut;
  logic        awValid, awReady, wValid, wReady, bValid, bReady;
  logic        arValid, arReady, rValid, rReady;
  logic [31:0] awAddr, wData, arAddr, rData;
  logic [3:0]  wStrb;
  logic [1:0]  bResp, rResp;

  always #4 clk = ~clk;

  axil_window_bridge #(.TimeoutCycles(Tmo)) u_axil_window_bridge (
    .clk(clk), .rstN(rstN), .hostAddr(hAddr), .hostWrEn(hWrEn), .hostWrData(hWrData),
    .hostRdData(hRdData), .irqIn(irqIn), .irqOut(irqOut), .awValid(awValid),
    .awReady(awReady), .awAddr(awAddr), .wValid(wValid), .wReady(wReady),
    .wData(wData), .wStrb(wStrb), .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr), .rValid(rValid),
    .rReady(rReady), .rData(rData), .rResp(rResp)
  );

  // ---------------- slave model ----------------
  int          lat = 0;
  logic        hang = 1'b0;
  logic [1:0]  respCode = 2'b00;
  logic [31:0] mem [16];
  int          wrCount, rdCount, cntW, cntR;
  logic        strbBad;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      awReady <= 0; wReady <= 0; bValid <= 0; bResp <= 0;
      arReady <= 0; rValid <= 0; rResp <= 0; rData <= 0;
      cntW <= 0; cntR <= 0; wrCount <= 0; rdCount <= 0; strbBad <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'h1000 + i * 32'h01010101;
    end else begin
      if (awReady) begin
        awReady <= 0; wReady <= 0; bValid <= 1; bResp <= respCode;
        if (respCode == 2'b00) mem[awAddr[5:2]] <= wData;
        if (wStrb != 4'hF) strbBad <= 1;
        wrCount <= wrCount + 1;
      end else if (awValid && wValid && !bValid && !hang) begin
        if (cntW >= lat) begin awReady <= 1; wReady <= 1; cntW <= 0; end
        else cntW <= cntW + 1;
      end else cntW <= 0;
      if (bValid && bReady) bValid <= 0;

      if (arReady) begin
        arReady <= 0; rValid <= 1; rResp <= respCode; rData <= mem[arAddr[5:2]];
        rdCount <= rdCount + 1;
      end else if (arValid && !rValid && !hang) begin
        if (cntR >= lat) begin arReady <= 1; cntR <= 0; end
        else cntR <= cntR + 1;
      end else cntR <= 0;
      if (rValid && rReady) rValid <= 0;
    end
  end

  // ---------------- checking ----------------
  int nChecks = 0, nFails = 0;
  logic runDone = 1'b0;
  logic [31:0] model [16];
  logic [31:0] expAddr, lastRd;
  logic        expRdAvail;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expStat(input logic [4:0] ev, input logic ra);
    return {ev, 3'b000, ra, 1'b0, 1'b1, 5'b00000};
  endfunction

  task automatic hostWr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); hAddr = a; hWrData = d; hWrEn = 1'b1;
    @(negedge clk); hWrEn = 1'b0;
  endtask

  task automatic hostRd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); hAddr = a; #1; d = hRdData;
  endtask

  task automatic waitIdle(output logic [15:0] s);
    for (int i = 0; i < 300; i++) begin
      hostRd(3'd0, s);
      if (!s[6]) break;
    end
  endtask

  task automatic readAddr(output logic [31:0] a);
    logic [15:0] lo, hi;
    hostRd(3'd2, lo); hostRd(3'd3, hi);
    a = {hi, lo};
  endtask

  task automatic startXfer(input logic isRd, input logic inc, input logic [31:0] a,
                           input logic [31:0] d, input logic [15:0] en);
    hostWr(3'd2, a[15:0]); hostWr(3'd3, a[31:16]);
    if (!isRd) begin hostWr(3'd4, d[15:0]); hostWr(3'd5, d[31:16]); end
    hostWr(3'd0, 16'hF800);
    hostWr(3'd1, en | {12'h0, 2'b10, isRd, inc});
  endtask

  initial begin
    logic [15:0] s, v;
    logic [31:0] a;
    int w0, r0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) model[i] = 32'h1000 + i * 32'h01010101;
    expRdAvail = 1'b0; lastRd = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    hostRd(3'd0, s); chk("R1 status after reset", 32'(s), 32'h0020);
    hostRd(3'd1, s); chk("R1 control after reset", 32'(s), 0);
    hostRd(3'd6, s); chk("R1 read-data low after reset", 32'(s), 0);
    readAddr(a);     chk("R1 address after reset", a, 0);
    chk("R1 irqOut after reset", 32'(irqOut), 0);

    // R12 NOP and unused codes
    w0 = wrCount; r0 = rdCount;
    hostWr(3'd1, 16'h0000); hostRd(3'd0, s);
    chk("R12 NOP leaves status", 32'(s), 32'h0020);
    hostWr(3'd1, 16'h0005); hostWr(3'd1, 16'h000C); hostRd(3'd0, s);
    chk("R12 unused codes leave status", 32'(s), 32'h0020);
    chk("R12 no bus transaction", 32'(wrCount + rdCount), 32'(w0 + r0));

    // R2 R11 write with mask, irq and W1C
    lat = 1; respCode = 2'b00;
    startXfer(1'b0, 1'b0, 32'hABCD_0008, 32'hDEAD_BEEF, 16'h4000);
    waitIdle(s); model[2] = 32'hDEAD_BEEF;
    chk("R2 write complete bit14", 32'(s), 32'(expStat(5'b01000, 1'b0)));
    chk("R11 irqOut with enabled event", 32'(irqOut), 1);
    hostRd(3'd1, s); chk("R11 control readback", 32'(s), 32'h4000);
    chk("R2 strobes all set", 32'(strbBad), 0);
    hostWr(3'd0, 16'h0000); hostRd(3'd0, s);
    chk("R9 write 0 keeps event", 32'(s), 32'(expStat(5'b01000, 1'b0)));
    hostWr(3'd0, 16'h4000); hostRd(3'd0, s);
    chk("R9 write 1 clears event", 32'(s), 32'h0020);
    chk("R11 irqOut falls after clear", 32'(irqOut), 0);

    // R10 downstream interrupt
    hostWr(3'd1, 16'h0000);
    @(negedge clk); irqIn = 1'b1; @(negedge clk); irqIn = 1'b0;
    repeat (3) @(negedge clk);
    hostRd(3'd0, s); chk("R10 sticky downstream event", 32'(s), 32'h0820);
    chk("R11 irqOut masked", 32'(irqOut), 0);
    hostWr(3'd1, 16'h0800); #1;
    chk("R11 irqOut after enabling bit11", 32'(irqOut), 1);
    hostWr(3'd0, 16'h0800); hostWr(3'd1, 16'h0000);

    // R4 wrap on post-increment
    startXfer(1'b0, 1'b1, 32'hFFFF_FFFC, 32'h1234_5678, 16'h0000);
    waitIdle(s); model[15] = 32'h1234_5678;
    readAddr(a); chk("R4 address wraps to 0", a, 0);

    // R8 commands and address writes ignored while busy
    lat = 12; w0 = wrCount;
    startXfer(1'b0, 1'b0, 32'h0000_0010, 32'h0BAD_F00D, 16'h0000);
    hostRd(3'd0, s); chk("R8 busy set during transfer", 32'(s[6]), 1);
    hostWr(3'd2, 16'h0020);
    hostWr(3'd1, 16'h0008);
    waitIdle(s); model[4] = 32'h0BAD_F00D;
    repeat (20) @(negedge clk);
    hostRd(3'd0, s); chk("R8 busy cleared", 32'(s[6]), 0);
    chk("R8 only one write issued", 32'(wrCount - w0), 1);
    readAddr(a); chk("R8 address write during busy ignored", a, 32'h10);

    // R6 timeout
    hang = 1'b1; lat = 0;
    startXfer(1'b0, 1'b1, 32'h0000_0030, 32'h5555_AAAA, 16'h0000);
    waitIdle(s);
    chk("R6 timeout event only", 32'(s), 32'(expStat(5'b00100, 1'b0)));
    chk("R6 valids dropped", 32'({awValid, wValid, arValid}), 0);
    readAddr(a); chk("R4 no increment after timeout", a, 32'h30);
    hang = 1'b0;

    // R3 R5 random mix
    for (int it = 0; it < 60; it++) begin
      logic isRd, inc, ok;
      logic [3:0] idx;
      logic [31:0] d, ad;
      int r;
      logic [4:0] ev;
      isRd = 1'($urandom); inc = 1'($urandom); idx = 4'($urandom);
      d = $urandom; ad = ($urandom & 32'hFFFF_FFC0) | {26'h0, idx, 2'b00};
      lat = $urandom % 4; r = $urandom % 8;
      respCode = (r == 0) ? 2'b10 : (r == 1) ? 2'b11 : 2'b00;
      ok = (respCode == 2'b00);
      startXfer(isRd, inc, ad, d, 16'h0000);
      waitIdle(s);
      if (isRd) begin
        if (ok) lastRd = model[idx];
        expRdAvail = ok;
        ev = ok ? 5'b10000 : 5'b00010;
      end else begin
        if (ok) model[idx] = d;
        ev = ok ? 5'b01000 : 5'b00010;
      end
      chk(isRd ? (ok ? "R3 read status" : "R5 read error status")
               : (ok ? "R2 write status" : "R5 write error status"),
          32'(s), 32'(expStat(ev, expRdAvail)));
      readAddr(a);
      chk("R4 address after transfer", a, (inc && ok) ? ad + 32'd4 : ad);
      if (isRd) begin
        hostRd(3'd6, s); hostRd(3'd7, v);
        chk("R3 R5 read data halves", {v, s}, lastRd);
      end
    end
    respCode = 2'b00;
    runDone = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!runDone) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule